// File: doc/BRIEF.md
# Bitwise Three-Input Lookup Execution Unit

This unit executes one instruction that evaluates an arbitrary three-input Boolean function independently on each of the 64 bit positions of its operands. The function is given as an 8-entry truth table carried in the instruction word. The three function inputs are the current value of the destination register and two source registers. Because the destination is also an input, the issue logic must read the old destination value and present it together with the two sources.

Each cycle the unit accepts a 32-bit instruction word, the three operand values and the current summary-overflow flag. It decodes the instruction word and checks that the instruction belongs to it. One cycle later it presents the new destination value, the destination register index, a register write enable and, when the record bit is set, a 4-bit condition field with its own write enable. Instructions with a different opcode are flagged as not belonging to the unit and cause no write.

Top module: `ternlut_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `out_mine`, `out_wen` and `out_cr_wen` are 0 after that edge.
- R2: `out_valid` equals the value of `in_valid` at the previous rising clock edge. When `in_valid` was 0, `out_wen`, `out_mine` and `out_cr_wen` are 0.
- R3: Instruction bits are numbered with bit 0 as the most significant bit (`insn[31]`). The unit claims an instruction (`out_mine`=1, `out_wen`=1) only when bits 0-5 (`insn[31:26]`) equal `PRIMARY_OP` and bits 29-30 (`insn[2:1]`) equal `EXT_OP`. Otherwise `out_mine`, `out_wen` and `out_cr_wen` are 0.
- R4: The truth table is the unsigned 8-bit value `tbl` = `insn[10:3]` (bits 21-28). For every bit i, `out_result[i]` = `tbl[j]`, with j = 4*`old_dst[i]` + 2*`src_a[i]` + `src_b[i]`.
- R5: The old destination value is the most significant index bit and `src_b` is the least significant index bit. `tbl`=8'h01 selects the all-zero case, 8'h10 selects only-`old_dst`-set, and 8'h80 selects all-ones.
- R6: `out_dst_idx` equals bits 6-10 of the instruction (`insn[25:21]`).
- R7: When the record bit (bit 31, `insn[0]`) is 0, `out_cr_wen` is 0.
- R8: When a claimed instruction has the record bit set, `out_cr_wen` is 1. `out_cr[3]` (less than) is 1 if the result is negative as a signed 64-bit value. `out_cr[2]` (greater than) is 1 if the result is positive and nonzero. `out_cr[1]` (equal) is 1 if the result is zero. Exactly one of these three bits is set.
- R9: `out_cr[0]` equals `so_in` as sampled together with the instruction.
- R10: When `in_valid` is 0, `out_result`, `out_dst_idx` and `out_cr` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are valid this cycle |
| insn | input | 32 | Instruction word |
| old_dst | input | 64 | Current value of the destination register |
| src_a | input | 64 | First source register value |
| src_b | input | 64 | Second source register value |
| so_in | input | 1 | Current summary-overflow flag |
| out_valid | output | 1 | A result slot is presented this cycle |
| out_mine | output | 1 | The presented instruction belongs to this unit |
| out_wen | output | 1 | Write `out_result` to the destination register |
| out_dst_idx | output | 5 | Destination register index |
| out_result | output | 64 | New destination value |
| out_cr_wen | output | 1 | Write `out_cr` to condition field 0 |
| out_cr | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The register write and the condition-field update fall in the same cycle whenever the record bit is set, and the condition bits must describe the very result being written. The bench covers this by sweeping all 256 tables with the record bit toggling. It also uses the constant-zero and constant-one tables, and a table that copies the old destination, so that the equal, less-than and greater-than outcomes each occur. In each of those cycles the bench compares the result, both enables and all four condition bits against its own minterm-sum model.

// File: rtl/ternlut_pkg.sv
// Package: shared field layout and constants for the bitwise three-input
// lookup unit. Assumes a 32-bit instruction word whose bit 0 (big-endian
// numbering) is insn[31].
package ternlut_pkg;

    localparam int INSN_W = 32;
    localparam int REG_IDX_W = 5;
    localparam int LUT_IN = 3;
    localparam int TBL_W = 1 << LUT_IN;
    localparam int CR_W = 4;

    // Positions inside the 4-bit condition field
    localparam int CR_LT = 3;
    localparam int CR_GT = 2;
    localparam int CR_EQ = 1;
    localparam int CR_SO = 0;

    // Instruction word, most significant field first
    typedef struct packed {
        logic [5:0]           pop;
        logic [REG_IDX_W-1:0] dst;
        logic [REG_IDX_W-1:0] sa;
        logic [REG_IDX_W-1:0] sb;
        logic [TBL_W-1:0]     tbl;
        logic [1:0]           xop;
        logic                 rec;
    } insn_fields_t;

endpackage

// File: rtl/ternlut_decode.sv
// Module: splits the instruction word into fields and decides whether the
// instruction belongs to this unit. Purely combinational; assumes the
// struct layout from ternlut_pkg matches the 32-bit word exactly.
module ternlut_decode
    import ternlut_pkg::*;
#(
    parameter logic [5:0] PRIMARY_OP = 6'd22,
    parameter logic [1:0] EXT_OP     = 2'd1
) (
    input  logic [INSN_W-1:0]    insn,
    output logic                 mine,
    output logic [REG_IDX_W-1:0] dst_idx,
    output logic [TBL_W-1:0]     tbl,
    output logic                 rec
);

    insn_fields_t f;

    // Field split and opcode match
    always_comb begin
        f       = insn_fields_t'(insn);
        mine    = (f.pop == PRIMARY_OP) && (f.xop == EXT_OP);
        dst_idx = f.dst;
        tbl     = f.tbl;
        rec     = f.rec;
    end

endmodule

// File: rtl/ternlut_lut.sv
// Module: per-bit three-input lookup. Each result bit picks one of the
// eight table entries, indexed by {old_dst, src_a, src_b} at that bit.
// Combinational; one 8:1 mux per bit position.
module ternlut_lut
    import ternlut_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]  old_dst,
    input  logic [XLEN-1:0]  src_a,
    input  logic [XLEN-1:0]  src_b,
    input  logic [TBL_W-1:0] tbl,
    output logic [XLEN-1:0]  result
);

    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        logic [LUT_IN-1:0] idx;
        // Index for bit i, destination as most significant input
        always_comb begin
            idx       = {old_dst[i], src_a[i], src_b[i]};
            result[i] = tbl[idx];
        end
    end

endmodule

// File: rtl/ternlut_cond.sv
// Module: builds the 4-bit condition field from a signed comparison of the
// result against zero plus the supplied summary-overflow flag.
// Combinational; assumes two's complement result.
module ternlut_cond
    import ternlut_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] result,
    input  logic            so,
    output logic [CR_W-1:0] cr
);

    logic neg;
    logic zero;

    // Sign/zero classification of the result
    always_comb begin
        neg       = result[XLEN-1];
        zero      = (result == '0);
        cr        = '0;
        cr[CR_LT] = neg;
        cr[CR_GT] = !neg && !zero;
        cr[CR_EQ] = zero;
        cr[CR_SO] = so;
    end

endmodule

// File: rtl/ternlut_unit.sv
// Module: top of the bitwise three-input lookup execution unit. Decodes the
// instruction, evaluates the per-bit lookup and condition field, and
// registers everything into a single output stage (latency one cycle).
// Assumes the issue logic supplies the old destination value as an operand.
module ternlut_unit
    import ternlut_pkg::*;
#(
    parameter int         XLEN       = 64,
    parameter logic [5:0] PRIMARY_OP = 6'd22,
    parameter logic [1:0] EXT_OP     = 2'd1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [INSN_W-1:0]    insn,
    input  logic [XLEN-1:0]      old_dst,
    input  logic [XLEN-1:0]      src_a,
    input  logic [XLEN-1:0]      src_b,
    input  logic                 so_in,
    output logic                 out_valid,
    output logic                 out_mine,
    output logic                 out_wen,
    output logic [REG_IDX_W-1:0] out_dst_idx,
    output logic [XLEN-1:0]      out_result,
    output logic                 out_cr_wen,
    output logic [CR_W-1:0]      out_cr
);

    logic                 dec_mine;
    logic [REG_IDX_W-1:0] dec_dst;
    logic [TBL_W-1:0]     dec_tbl;
    logic                 dec_rec;
    logic [XLEN-1:0]      lut_result;
    logic [CR_W-1:0]      cond_field;

    ternlut_decode #(
        .PRIMARY_OP (PRIMARY_OP),
        .EXT_OP     (EXT_OP)
    ) u_decode (
        .insn    (insn),
        .mine    (dec_mine),
        .dst_idx (dec_dst),
        .tbl     (dec_tbl),
        .rec     (dec_rec)
    );

    ternlut_lut #(.XLEN(XLEN)) u_lut (
        .old_dst (old_dst),
        .src_a   (src_a),
        .src_b   (src_b),
        .tbl     (dec_tbl),
        .result  (lut_result)
    );

    ternlut_cond #(.XLEN(XLEN)) u_cond (
        .result (lut_result),
        .so     (so_in),
        .cr     (cond_field)
    );

    // Control flags of the output stage: valid, claim and write enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_mine   <= 1'b0;
            out_wen    <= 1'b0;
            out_cr_wen <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            out_mine   <= in_valid && dec_mine;
            out_wen    <= in_valid && dec_mine;
            out_cr_wen <= in_valid && dec_mine && dec_rec;
        end
    end

    // Data payload of the output stage, captured only for a valid slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_dst_idx <= '0;
            out_result  <= '0;
            out_cr      <= '0;
        end else if (in_valid) begin
            out_dst_idx <= dec_dst;
            out_result  <= lut_result;
            out_cr      <= cond_field;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_mine && !out_wen && !out_cr_wen)); // R1

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_WEN_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_wen |-> (out_valid && out_mine)); // R3

    AST_CR_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_cr_wen |-> out_wen); // R7

    AST_CR_ONE_RELATION: assert property (@(posedge clk) disable iff (!rst_n)
        out_cr_wen |-> ($countones(out_cr[CR_LT:CR_EQ]) == 1)); // R8

    AST_EQ_MATCHES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_cr_wen |-> (out_cr[CR_EQ] == (out_result == '0))); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_cr))); // R10

endmodule

// File: tb/tb_ternlut_unit.sv
module tb_ternlut_unit;

    localparam logic [5:0] POP = 6'd22;
    localparam logic [1:0] XOP = 2'd1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] old_dst = '0, src_a = '0, src_b = '0;
    logic        so_in = 1'b0;
    logic        out_valid, out_mine, out_wen, out_cr_wen;
    logic [4:0]  out_dst_idx;
    logic [63:0] out_result;
    logic [3:0]  out_cr;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ternlut_unit #(.XLEN(64), .PRIMARY_OP(POP), .EXT_OP(XOP)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .old_dst(old_dst), .src_a(src_a), .src_b(src_b), .so_in(so_in),
        .out_valid(out_valid), .out_mine(out_mine), .out_wen(out_wen),
        .out_dst_idx(out_dst_idx), .out_result(out_result),
        .out_cr_wen(out_cr_wen), .out_cr(out_cr)
    );

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rt,
                                       input logic [4:0] ra, input logic [4:0] rb,
                                       input logic [7:0] t, input logic [1:0] xo,
                                       input logic rc);
        return {op, rt, ra, rb, t, xo, rc};
    endfunction

    // Minterm-sum reference model
    function automatic logic [63:0] model(input logic [7:0] t, input logic [63:0] d,
                                          input logic [63:0] a, input logic [63:0] b);
        return (~d & ~a & ~b & {64{t[0]}}) | (~d & ~a &  b & {64{t[1]}}) |
               (~d &  a & ~b & {64{t[2]}}) | (~d &  a &  b & {64{t[3]}}) |
               ( d & ~a & ~b & {64{t[4]}}) | ( d & ~a &  b & {64{t[5]}}) |
               ( d &  a & ~b & {64{t[6]}}) | ( d &  a &  b & {64{t[7]}});
    endfunction

    function automatic logic [3:0] cr_model(input logic [63:0] r, input logic so);
        logic lt, eq;
        lt = r[63];
        eq = (r == 64'd0);
        return {lt, !lt && !eq, eq, so};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one slot at a falling edge; outputs are sampled at the next falling edge
    task automatic issue(input logic [31:0] w, input logic [63:0] d, input logic [63:0] a,
                         input logic [63:0] b, input logic so);
        @(negedge clk);
        insn = w; old_dst = d; src_a = a; src_b = b; so_in = so; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_full(input logic [7:0] t, input logic rc, input logic so,
                            input logic [63:0] d, input logic [63:0] a, input logic [63:0] b,
                            input string req);
        logic [63:0] r;
        r = model(t, d, a, b);
        issue(mk(POP, 5'd9, 5'd3, 5'd4, t, XOP, rc), d, a, b, so);
        check(req, out_result, r);
        check("R3 wen", {63'd0, out_wen}, 64'd1);
        check("R7/R8 cr_wen", {63'd0, out_cr_wen}, {63'd0, rc});
        if (rc) check("R8/R9 cr", {60'd0, out_cr}, {60'd0, cr_model(r, so)});
    endtask

    initial begin
        logic [63:0] d, a, b, keep;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 valid", {63'd0, out_valid}, 64'd0);
        check("R1 wen", {63'd0, out_wen}, 64'd0);
        check("R1 cr_wen", {63'd0, out_cr_wen}, 64'd0);
        rst_n = 1'b1;

        // R4 exhaustive table sweep with random operands, record bit toggling
        for (int t = 0; t < 256; t++) begin
            for (int k = 0; k < 2; k++) begin
                d = {$urandom, $urandom}; a = {$urandom, $urandom}; b = {$urandom, $urandom};
                run_full(t[7:0], k[0], t[1], d, a, b, "R4 sweep");
            end
        end

        // R5 index ordering with orthogonal patterns
        d = 64'hF0F0_F0F0_F0F0_F0F0; a = 64'hCCCC_CCCC_CCCC_CCCC; b = 64'hAAAA_AAAA_AAAA_AAAA;
        run_full(8'h01, 1'b0, 1'b0, d, a, b, "R5 all-zero minterm");
        check("R5 explicit 01", out_result, 64'h0101_0101_0101_0101);
        run_full(8'h10, 1'b0, 1'b0, d, a, b, "R5 rt-only minterm");
        check("R5 explicit 10", out_result, 64'h1010_1010_1010_1010);
        run_full(8'h80, 1'b0, 1'b0, d, a, b, "R5 all-one minterm");
        check("R5 explicit 80", out_result, 64'h8080_8080_8080_8080);

        // R6 destination index
        issue(mk(POP, 5'd27, 5'd1, 5'd2, 8'hF0, XOP, 1'b0), d, a, b, 1'b0);
        check("R6 dst_idx", {59'd0, out_dst_idx}, 64'd27);

        // R8 EQ / LT / GT, R9 summary overflow copy
        run_full(8'h00, 1'b1, 1'b1, d, a, b, "R8 zero result");
        check("R8 EQ", {60'd0, out_cr}, 64'b0011);
        run_full(8'hFF, 1'b1, 1'b0, d, a, b, "R8 negative result");
        check("R8 LT", {60'd0, out_cr}, 64'b1000);
        run_full(8'hF0, 1'b1, 1'b1, 64'd5, a, b, "R8 positive result");
        check("R8 GT R9 SO", {60'd0, out_cr}, 64'b0101);

        // R3 wrong primary and wrong extended opcode
        keep = out_result;
        issue(mk(POP ^ 6'd1, 5'd9, 5'd3, 5'd4, 8'hFF, XOP, 1'b1), d, a, b, 1'b0);
        check("R3 bad primary mine", {63'd0, out_mine}, 64'd0);
        check("R3 bad primary wen", {63'd0, out_wen}, 64'd0);
        check("R3 bad primary cr_wen", {63'd0, out_cr_wen}, 64'd0);
        check("R2 valid with foreign insn", {63'd0, out_valid}, 64'd1);
        issue(mk(POP, 5'd9, 5'd3, 5'd4, 8'hFF, XOP ^ 2'd3, 1'b1), d, a, b, 1'b0);
        check("R3 bad ext mine", {63'd0, out_mine}, 64'd0);
        check("R3 bad ext wen", {63'd0, out_wen}, 64'd0);

        // R2 / R10 idle cycles: no valid, payload held
        run_full(8'hCA, 1'b1, 1'b0, d, a, b, "R10 setup");
        keep = out_result;
        @(negedge clk);
        insn = mk(POP, 5'd1, 5'd1, 5'd1, 8'h00, XOP, 1'b1);
        old_dst = '1; src_a = '1; src_b = '1;
        @(negedge clk);
        check("R2 idle valid", {63'd0, out_valid}, 64'd0);
        check("R2 idle wen", {63'd0, out_wen}, 64'd0);
        check("R2 idle cr_wen", {63'd0, out_cr_wen}, 64'd0);
        check("R10 result held", out_result, keep);
        check("R10 dst held", {59'd0, out_dst_idx}, 64'd9);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule